// File: doc/BRIEF.md
# L2-Side L1 Sharer Directory

This block sits beside one bank of a shared second-level cache. It records which of eight per-core first-level data caches hold a copy of each block that the bank holds, and it decides which cores must drop their copy. The first-level caches are write-through, so coherence never needs data back from a core: the directory only sends invalidations. Presence information lives in a small associative table. Each entry is looked up by block address and holds one presence bit per core.

Requests arrive one at a time on a valid/ready port. There are four kinds: a load fill into a core, a store from a core, a notice that a core evicted its copy, and an eviction of the block from the second-level cache. Stores do not allocate in the first level, so a store never makes the writer a sharer. The first level is kept a subset of the second, so a second-level eviction removes every copy. Any invalidation is presented for one cycle as a vector of target cores with a valid strobe.

When a load fill misses the table and no entry is free, the port holds ready low for that request. Other request kinds are still accepted while the load waits. A second-level eviction frees an entry, and after that the load can be taken.

Top module: `sharer_dir`

## Requirements
- R1: After reset `inv_valid` is 0, `inv_vec` is 0, `req_ready` is 1 and the table is empty, so no request finds a tracked block.
- R2: An accepted load fill (`req_op` = 0) sets the presence bit of `req_core` for the block, allocating an entry on a table miss, and sends no invalidation.
- R3: An accepted store (`req_op` = 1) to a tracked block invalidates every sharer except the writer and clears their bits. The writer's own bit keeps its value.
- R4: A store never sets the writer's presence bit. This holds whether the block is tracked or not.
- R5: An accepted first-level eviction notice (`req_op` = 2) clears that core's bit and sends no invalidation.
- R6: An entry whose presence vector becomes zero is released and can be reused by a later load fill.
- R7: An accepted second-level eviction (`req_op` = 3) invalidates every core whose bit is set and frees the entry.
- R8: `inv_valid` is high for exactly one cycle per invalidation, with `inv_vec` bit n set for core n. `req_ready` is low in that cycle.
- R9: A load fill that misses with every entry in use sees `req_ready` low and is not taken. Other request kinds are still accepted.
- R10: A store, eviction notice or second-level eviction for an untracked block produces no invalidation and allocates nothing.
- R11: `inv_vec` is zero whenever `inv_valid` is low, and nonzero whenever it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load fill, 1 store, 2 first-level eviction notice, 3 second-level eviction |
| req_addr | input | ADDR_W | Block address |
| req_core | input | 3 | Requesting core |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| inv_valid | output | 1 | Invalidation vector valid for this cycle |
| inv_vec | output | NUM_CORES | One bit per core to invalidate |

## Verification
A presence bit left set or wrongly cleared cannot be read directly. It shows up at the next store or second-level eviction of that block, as an extra or missing bit in `inv_vec` exactly one cycle after that request is accepted. So the stimulus always ends a sequence with an eviction that exposes the whole vector. A release that fails to happen, or an allocation that leaks, shows only when the table fills: a later load fill is then refused or accepted wrongly. For this reason the table is driven to capacity and the release paths are checked through the ready signal.

// File: rtl/sharer_dir_pkg.sv
// Package: shared request encoding for the sharer directory.
// Assumes: the op code values are fixed, because the requester encodes them.
package sharer_dir_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_FILL = 2'd0,
        OP_STORE     = 2'd1,
        OP_L1_EVICT  = 2'd2,
        OP_L2_EVICT  = 2'd3
    } dir_op_e;
endpackage

// File: rtl/sharer_dir_cam.sv
// Module: associative lookup over the directory tags.
// What it does: compares the request address against every valid tag and reports
// hit plus index. It also finds the lowest-numbered free entry.
// Assumes: at most one valid tag matches any address (the top never duplicates).
module sharer_dir_cam #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ADDR_W-1:0]              lookup_addr,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free_any,
    output logic [IDX_W-1:0]               free_idx
);
    logic [ENTRIES-1:0] match;

    // Per-entry comparator, one per table slot.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid[e] && (tags[e] == lookup_addr);
    end

    // Encode the matching slot (unique by assumption).
    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) hit_idx = IDX_W'(e);
        end
        hit = |match;
    end

    // Pick the lowest-numbered free slot for allocation.
    always_comb begin
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!valid[e]) free_idx = IDX_W'(e);
        end
        free_any = ~&valid;
    end
endmodule

// File: rtl/sharer_dir_update.sv
// Module: next-state rule for one presence vector.
// What it does: given the op, the requesting core and the current vector, it
// produces the new vector, the invalidation targets and whether the entry stays valid.
// Assumes: cur_vec is zero when hit is low.
module sharer_dir_update
    import sharer_dir_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int CORE_W   = $clog2(NUM_CORES)
) (
    input  dir_op_e              op,
    input  logic [CORE_W-1:0]    core,
    input  logic                 hit,
    input  logic [NUM_CORES-1:0] cur_vec,
    output logic [NUM_CORES-1:0] next_vec,
    output logic [NUM_CORES-1:0] inv,
    output logic                 keep
);
    logic [NUM_CORES-1:0] core_bit;

    // One-hot of the requesting core.
    always_comb core_bit = {{(NUM_CORES-1){1'b0}}, 1'b1} << core;

    // Apply the coherence rule for the request kind.
    always_comb begin
        next_vec = cur_vec;
        inv      = '0;
        unique case (op)
            OP_LOAD_FILL: next_vec = cur_vec | core_bit;
            OP_STORE: begin
                inv      = cur_vec & ~core_bit;
                next_vec = cur_vec & core_bit;
            end
            OP_L1_EVICT: next_vec = cur_vec & ~core_bit;
            OP_L2_EVICT: begin
                inv      = cur_vec;
                next_vec = '0;
            end
        endcase
        if (!hit && op != OP_LOAD_FILL) begin
            inv      = '0;
            next_vec = '0;
        end
        keep = |next_vec;
    end
endmodule

// File: rtl/sharer_dir.sv
// Module: top of the second-level-side sharer directory.
// What it does: holds tag, valid and presence vector per entry. It accepts one
// request per cycle and registers any invalidation as a one-cycle pulse.
// Assumes: ENTRIES is a power of two; the requester holds a refused request
// stable or replaces it with another kind.
module sharer_dir
    import sharer_dir_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int ENTRIES   = 4,
    parameter int ADDR_W    = 12,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CORE_W-1:0]    req_core,
    output logic                 req_ready,
    output logic                 inv_valid,
    output logic [NUM_CORES-1:0] inv_vec
);
    logic [ENTRIES-1:0][ADDR_W-1:0]    tag_q;
    logic [ENTRIES-1:0]                vld_q;
    logic [ENTRIES-1:0][NUM_CORES-1:0] vec_q;
    logic                              inv_valid_q;
    logic [NUM_CORES-1:0]              inv_vec_q;

    dir_op_e              op;
    logic                 hit, free_any, tbl_full_stall, accept, wr_en, keep;
    logic [IDX_W-1:0]     hit_idx, free_idx, tgt_idx;
    logic [NUM_CORES-1:0] cur_vec, next_vec, inv;

    // Decode the op field into the shared enum.
    always_comb op = dir_op_e'(req_op);

    sharer_dir_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) cam_i (
        .tags(tag_q), .valid(vld_q), .lookup_addr(req_addr),
        .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
    );

    // Read the matching vector, or zero on a miss.
    always_comb cur_vec = hit ? vec_q[hit_idx] : '0;

    sharer_dir_update #(.NUM_CORES(NUM_CORES)) upd_i (
        .op(op), .core(req_core), .hit(hit), .cur_vec(cur_vec),
        .next_vec(next_vec), .inv(inv), .keep(keep)
    );

    // Handshake: refuse during an invalidation pulse or a load miss into a full table.
    always_comb begin
        tbl_full_stall = req_valid && (op == OP_LOAD_FILL) && !hit && !free_any;
        req_ready      = !inv_valid_q && !tbl_full_stall;
        accept         = req_valid && req_ready;
        wr_en          = accept && (hit || (op == OP_LOAD_FILL && free_any));
        tgt_idx        = hit ? hit_idx : free_idx;
    end

    // Table state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            vec_q <= '0;
            tag_q <= '0;
        end else if (wr_en) begin
            vld_q[tgt_idx] <= keep;
            vec_q[tgt_idx] <= next_vec;
            if (!hit) tag_q[tgt_idx] <= req_addr;
        end
    end

    // Register the invalidation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid_q <= 1'b0;
            inv_vec_q   <= '0;
        end else begin
            inv_valid_q <= accept && (|inv);
            inv_vec_q   <= accept ? inv : '0;
        end
    end

    assign inv_valid = inv_valid_q;
    assign inv_vec   = inv_vec_q;
endmodule

// File: rtl/sharer_dir_chk.sv
// Module: protocol checker for sharer_dir, attached by bind below.
// What it does: checks the pulse shape, the handshake and the per-op invalidation rules at the ports.
// Assumes: synchronous active-low reset as in the top.
module sharer_dir_chk
    import sharer_dir_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int CORE_W   = $clog2(NUM_CORES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_op,
    input logic [CORE_W-1:0]    req_core,
    input logic                 req_ready,
    input logic                 inv_valid,
    input logic [NUM_CORES-1:0] inv_vec
);
    p_pulse_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);

    p_busy_during_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready);

    p_vec_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |-> (inv_vec == '0));

    p_vec_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_vec != '0));

    p_writer_spared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'(OP_STORE)) |=> (inv_vec[$past(req_core)] == 1'b0));

    p_l1_notice_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'(OP_L1_EVICT)) |=> !inv_valid);

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'(OP_LOAD_FILL)) |=> !inv_valid);
endmodule

bind sharer_dir sharer_dir_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_ready(req_ready), .inv_valid(inv_valid), .inv_vec(inv_vec)
);

// File: tb/sharer_dir_tb.sv
`timescale 1ns/1ps
module sharer_dir_tb_top;
    localparam int NC = 8, NE = 4, AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_core = '0;
    logic          req_ready, inv_valid;
    logic [NC-1:0] inv_vec;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    sharer_dir #(.NUM_CORES(NC), .ENTRIES(NE), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_core(req_core), .req_ready(req_ready),
        .inv_valid(inv_valid), .inv_vec(inv_vec)
    );

    // Vector fields: op[25:24] core[23:21] addr[20:9] exp_valid[8] exp_vec[7:0]
    localparam logic [25:0] VEC [16] = '{
        {2'd0, 3'd0, 12'h010, 1'b0, 8'h00},
        {2'd0, 3'd3, 12'h010, 1'b0, 8'h00},
        {2'd0, 3'd5, 12'h010, 1'b0, 8'h00},
        {2'd1, 3'd3, 12'h010, 1'b1, 8'h21},
        {2'd0, 3'd1, 12'h010, 1'b0, 8'h00},
        {2'd3, 3'd0, 12'h010, 1'b1, 8'h0A},
        {2'd3, 3'd0, 12'h010, 1'b0, 8'h00},
        {2'd1, 3'd2, 12'h020, 1'b0, 8'h00},
        {2'd0, 3'd6, 12'h020, 1'b0, 8'h00},
        {2'd1, 3'd2, 12'h020, 1'b1, 8'h40},
        {2'd3, 3'd0, 12'h020, 1'b0, 8'h00},
        {2'd0, 3'd4, 12'h030, 1'b0, 8'h00},
        {2'd0, 3'd7, 12'h030, 1'b0, 8'h00},
        {2'd2, 3'd4, 12'h030, 1'b0, 8'h00},
        {2'd1, 3'd0, 12'h030, 1'b1, 8'h80},
        {2'd2, 3'd1, 12'h040, 1'b0, 8'h00}
    };
    string vtag [16] = '{"R2", "R2", "R2", "R3", "R2", "R7", "R7", "R10",
                         "R2", "R4", "R4", "R2", "R2", "R5", "R5", "R10"};

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One accepted request, then a check of the pulse and, if a pulse came, of the cycle after it (R8).
    task automatic apply(string tag, logic [1:0] op, logic [2:0] core, logic [AW-1:0] addr,
                         logic ev, logic [NC-1:0] evec);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_core = core; req_addr = addr;
        #1;
        check({tag, " ready"}, 32'(req_ready), 32'd1);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check({tag, " inv_valid"}, 32'(inv_valid), 32'(ev));
        check({tag, " inv_vec"}, 32'(inv_vec), 32'(evec));
        if (ev) begin
            check("R8 ready low in pulse", 32'(req_ready), 32'd0);
            @(negedge clk);
            check("R8 pulse ends", 32'(inv_valid), 32'd0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 inv_valid", 32'(inv_valid), 32'd0);
        check("R1 inv_vec", 32'(inv_vec), 32'd0);
        check("R1 ready", 32'(req_ready), 32'd1);

        for (int i = 0; i < 16; i++) begin
            apply(vtag[i], VEC[i][25:24], VEC[i][23:21], VEC[i][20:9], VEC[i][8], VEC[i][7:0]);
        end

        // R9: fill every entry, then a load miss must be refused.
        for (int k = 0; k < NE; k++) begin
            apply("R9 fill", 2'd0, 3'd0, AW'(12'h100 + k), 1'b0, 8'h00);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_core = 3'd0; req_addr = 12'h1F0;
        for (int k = 0; k < 3; k++) begin
            #1 check("R9 full refuses load", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R9: another kind is still accepted; R7 frees the entry.
        apply("R7 evict frees", 2'd3, 3'd0, 12'h100, 1'b1, 8'h01);
        apply("R9 load after free", 2'd0, 3'd2, 12'h1F0, 1'b0, 8'h00);
        // R6: a notice that empties a vector releases the entry.
        apply("R6 notice", 2'd2, 3'd0, 12'h101, 1'b0, 8'h00);
        apply("R6 reuse", 2'd0, 3'd1, 12'h1F1, 1'b0, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_core = 3'd0; req_addr = 12'h1F2;
        #1 check("R9 full again", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        // R2: fill by core 2 on a fresh entry shows up as its bit at eviction.
        apply("R2 fill bit", 2'd3, 3'd0, 12'h1F0, 1'b1, 8'h04);

        // R1: reset mid-run clears the table.
        do_reset();
        apply("R1 table cleared", 2'd3, 3'd0, 12'h102, 1'b0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule